// File: doc/BRIEF.md
# Two-Window Display Register Bank with Frame-Synchronous Commit

This block holds the per-window setup of a two-window display pipeline. It keeps two copies of every field. Software writes land in a staging (shadow) copy. The scan-out logic only ever sees the live (active) copy. Staged values move into the live copy on a vertical-sync pulse, and only after software has asked for an update.

Each window has a hold bit. While it is set, that window's copy at vsync is blocked. Software can therefore rewrite several registers of a window over any number of cycles, and scan-out sees either all of the old values or all of the new ones. An update request that is blocked for one window stays pending for that window. It completes at the first vsync after the hold bit is released. Clearing a window's enable bit is an ordinary staged write, so the window keeps scanning out until the next vsync.

The live window corners are derived when the values are copied. The far (inclusive) corner is the near corner plus the size, minus one, clamped at zero. Only the second window carries a colour-key register. All reads return the staged values.

Top module: `disp_shadow_bank`

## Requirements
- R1: A write to any window register changes only the staged copy. The live outputs change only at a vsync pulse on which a commit takes place.
- R2: While hold bit w (bit w of the control register at address 0x10) is set at a vsync, every live output of window w keeps its value.
- R3: After a window's hold bit is cleared, an update that the hold bit blocked is applied to that window at the next vsync, with no new request.
- R4: Clearing the enable bit (bit 0 at offset 0) leaves the live enable of that window at 1 until the next committing vsync, and then drops it to 0.
- R5: Writing 1 to bit 8 of the control register requests a commit for every window. Bit 8 reads 1 while any window has not yet committed and 0 once all windows have. Writing 0 to bit 8 never cancels a request.
- R6: A vsync pulse with no pending request leaves every live output unchanged.
- R7: Window register offset 0 holds enable (bit 0), triple-buffer mode (bit 1), long burst (bit 2) and a 4-bit pixel format (bits 7:4). Each of these reaches its live output on commit.
- R8: Window 0 has no colour key. A write to its offset 4 is ignored, it reads 0, and its live key stays 0. Window 1's key at offset 4 is stored, read back and committed.
- R9: Reading any register returns the staged value last written. Window w sits at base w*8 with offsets 0 to 4. Offset 1 is the buffer address. Offset 2 is the top-left corner, x in bits 11:0 and y in bits 27:16. Offset 3 is the size, width in bits 11:0 and height in bits 27:16. Undefined offsets read 0.
- R10: After reset, all staged and live values are 0, no window is enabled, no hold bit is set, and no request is pending.
- R11: On commit, the live far corner is (near corner + size - 1) per axis, computed in 13 bits and truncated to 12 bits. A result that would be -1 becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 5 | Register read address |
| rd_data | output | 32 | Staged value at rd_addr (combinational) |
| vsync | input | 1 | One-cycle vertical-sync pulse |
| act_en | output | 2 | Live window enable, one bit per window |
| act_tbuf | output | 2 | Live triple-buffer mode per window |
| act_burst | output | 2 | Live long-burst select per window |
| act_fmt | output | 8 | Live pixel format, 4 bits per window |
| act_base | output | 64 | Live buffer address, 32 bits per window |
| act_tlx | output | 24 | Live top-left x, 12 bits per window |
| act_tly | output | 24 | Live top-left y, 12 bits per window |
| act_brx | output | 24 | Live bottom-right x, 12 bits per window |
| act_bry | output | 24 | Live bottom-right y, 12 bits per window |
| act_ckey | output | 64 | Live colour key, 32 bits per window (window 0 always 0) |

## Verification
The bench targets an update request split by a hold bit. A design that drops the request for the held window would never show its new address after the release. A design that ignores the hold bit would show the new address one frame early. It also checks that the request bit survives a partial commit, and that a vsync with no request does nothing; a bank that copies on every vsync would leak half-written values. The far-corner vectors cover zero size at the origin, wrap at the top of the 12-bit range, and a zero-size window away from the origin, which catches a missing or misplaced clamp.

// File: rtl/dsb_pkg.sv
package dsb_pkg;

    parameter int unsigned DSB_POS_W  = 12;
    parameter int unsigned DSB_ADDR_W = 32;
    parameter int unsigned DSB_FMT_W  = 4;
    parameter int unsigned DSB_KEY_W  = 32;
    parameter int unsigned DSB_DATA_W = 32;
    parameter int unsigned DSB_REG_AW = 3;

    localparam logic [DSB_REG_AW-1:0] OFF_CTRL = 'd0;
    localparam logic [DSB_REG_AW-1:0] OFF_BASE = 'd1;
    localparam logic [DSB_REG_AW-1:0] OFF_TL   = 'd2;
    localparam logic [DSB_REG_AW-1:0] OFF_SIZE = 'd3;
    localparam logic [DSB_REG_AW-1:0] OFF_KEY  = 'd4;

    localparam int unsigned FMT_LSB = 4;
    localparam int unsigned Y_LSB   = 16;
    localparam int unsigned UPD_BIT = 8;

    typedef struct packed {
        logic                  en;
        logic                  tbuf;
        logic                  burst;
        logic [DSB_FMT_W-1:0]  fmt;
        logic [DSB_ADDR_W-1:0] base;
        logic [DSB_POS_W-1:0]  tlx;
        logic [DSB_POS_W-1:0]  tly;
        logic [DSB_POS_W-1:0]  szw;
        logic [DSB_POS_W-1:0]  szh;
        logic [DSB_KEY_W-1:0]  ckey;
    } win_stage_t;

    typedef struct packed {
        logic                  en;
        logic                  tbuf;
        logic                  burst;
        logic [DSB_FMT_W-1:0]  fmt;
        logic [DSB_ADDR_W-1:0] base;
        logic [DSB_POS_W-1:0]  tlx;
        logic [DSB_POS_W-1:0]  tly;
        logic [DSB_POS_W-1:0]  brx;
        logic [DSB_POS_W-1:0]  bry;
        logic [DSB_KEY_W-1:0]  ckey;
    } win_live_t;

    // inclusive far edge: start + length - 1, held at zero instead of going negative
    function automatic logic [DSB_POS_W-1:0] far_edge(
        input logic [DSB_POS_W-1:0] start,
        input logic [DSB_POS_W-1:0] len
    );
        logic [DSB_POS_W:0] sum;
        sum = {1'b0, start} + {1'b0, len};
        if (sum == '0) return '0;
        sum = sum - 1'b1;
        return sum[DSB_POS_W-1:0];
    endfunction

endpackage

// File: rtl/dsb_window.sv
module dsb_window
    import dsb_pkg::*;
#(
    parameter bit HAS_KEY = 1'b0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [DSB_REG_AW-1:0] wr_off,
    input  logic [DSB_DATA_W-1:0] wr_data,
    input  logic                  commit,
    output win_stage_t            stage_o,
    output win_live_t             live_o
);

    typedef struct packed {
        win_stage_t sh;
        win_live_t  act;
    } win_state_t;

    win_state_t st_d, st_q;
    logic       unused_wr_bits;

    assign unused_wr_bits = ^wr_data;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (wr_off)
                OFF_CTRL: begin
                    st_d.sh.en    = wr_data[0];
                    st_d.sh.tbuf  = wr_data[1];
                    st_d.sh.burst = wr_data[2];
                    st_d.sh.fmt   = wr_data[FMT_LSB +: DSB_FMT_W];
                end
                OFF_BASE: st_d.sh.base = wr_data[DSB_ADDR_W-1:0];
                OFF_TL: begin
                    st_d.sh.tlx = wr_data[0 +: DSB_POS_W];
                    st_d.sh.tly = wr_data[Y_LSB +: DSB_POS_W];
                end
                OFF_SIZE: begin
                    st_d.sh.szw = wr_data[0 +: DSB_POS_W];
                    st_d.sh.szh = wr_data[Y_LSB +: DSB_POS_W];
                end
                OFF_KEY: begin
                    if (HAS_KEY) st_d.sh.ckey = wr_data[DSB_KEY_W-1:0];
                end
                default: ;
            endcase
        end
        // commit copies the staging image as it stood before this cycle's write
        if (commit) begin
            st_d.act.en    = st_q.sh.en;
            st_d.act.tbuf  = st_q.sh.tbuf;
            st_d.act.burst = st_q.sh.burst;
            st_d.act.fmt   = st_q.sh.fmt;
            st_d.act.base  = st_q.sh.base;
            st_d.act.tlx   = st_q.sh.tlx;
            st_d.act.tly   = st_q.sh.tly;
            st_d.act.brx   = far_edge(st_q.sh.tlx, st_q.sh.szw);
            st_d.act.bry   = far_edge(st_q.sh.tly, st_q.sh.szh);
            st_d.act.ckey  = HAS_KEY ? st_q.sh.ckey : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stage_o = st_q.sh;
    assign live_o  = st_q.act;

endmodule

// File: rtl/dsb_sync_ctrl.sv
module dsb_sync_ctrl
    import dsb_pkg::*;
#(
    parameter int unsigned NUM_WIN = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [DSB_DATA_W-1:0] wr_data,
    input  logic                  vsync,
    output logic [NUM_WIN-1:0]    hold_o,
    output logic [NUM_WIN-1:0]    pend_o,
    output logic [NUM_WIN-1:0]    commit_o,
    output logic                  req_set_o
);

    typedef struct packed {
        logic [NUM_WIN-1:0] hold;
        logic [NUM_WIN-1:0] pend;
    } ctl_state_t;

    ctl_state_t st_d, st_q;
    logic       unused_wr_bits;

    assign unused_wr_bits = ^wr_data;
    assign req_set_o = wr_en & wr_data[UPD_BIT];
    assign commit_o  = {NUM_WIN{vsync}} & st_q.pend & ~st_q.hold;

    always_comb begin
        st_d      = st_q;
        st_d.pend = st_q.pend & ~commit_o;
        if (wr_en) st_d.hold = wr_data[NUM_WIN-1:0];
        // a fresh request wins over a same-cycle completion
        if (req_set_o) st_d.pend = '1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hold_o = st_q.hold;
    assign pend_o = st_q.pend;

endmodule

// File: rtl/dsb_read_mux.sv
module dsb_read_mux
    import dsb_pkg::*;
#(
    parameter int unsigned NUM_WIN = 2,
    parameter int unsigned WIN_AW  = 1,
    parameter int unsigned BUS_AW  = 5
) (
    input  win_stage_t [NUM_WIN-1:0] stages,
    input  logic [NUM_WIN-1:0]       hold,
    input  logic [NUM_WIN-1:0]       pend,
    input  logic [BUS_AW-1:0]        rd_addr,
    output logic [DSB_DATA_W-1:0]    rd_data
);

    win_stage_t            sel;
    logic [WIN_AW-1:0]     widx;
    logic [DSB_REG_AW-1:0] off;

    assign widx = rd_addr[DSB_REG_AW +: WIN_AW];
    assign off  = rd_addr[DSB_REG_AW-1:0];

    always_comb begin
        rd_data = '0;
        sel     = '0;
        if (rd_addr[BUS_AW-1]) begin
            rd_data[NUM_WIN-1:0] = hold;
            rd_data[UPD_BIT]     = |pend;
        end else if (int'(widx) < NUM_WIN) begin
            sel = stages[widx];
            case (off)
                OFF_CTRL: begin
                    rd_data[0] = sel.en;
                    rd_data[1] = sel.tbuf;
                    rd_data[2] = sel.burst;
                    rd_data[FMT_LSB +: DSB_FMT_W] = sel.fmt;
                end
                OFF_BASE: rd_data[DSB_ADDR_W-1:0] = sel.base;
                OFF_TL: begin
                    rd_data[0 +: DSB_POS_W]     = sel.tlx;
                    rd_data[Y_LSB +: DSB_POS_W] = sel.tly;
                end
                OFF_SIZE: begin
                    rd_data[0 +: DSB_POS_W]     = sel.szw;
                    rd_data[Y_LSB +: DSB_POS_W] = sel.szh;
                end
                OFF_KEY: rd_data[DSB_KEY_W-1:0] = sel.ckey;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/disp_shadow_bank.sv
module disp_shadow_bank
    import dsb_pkg::*;
#(
    parameter  int unsigned NUM_WIN = 2,
    localparam int unsigned WIN_AW  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
    localparam int unsigned BUS_AW  = WIN_AW + DSB_REG_AW + 1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [BUS_AW-1:0]               wr_addr,
    input  logic [DSB_DATA_W-1:0]           wr_data,
    input  logic [BUS_AW-1:0]               rd_addr,
    output logic [DSB_DATA_W-1:0]           rd_data,
    input  logic                            vsync,
    output logic [NUM_WIN-1:0]              act_en,
    output logic [NUM_WIN-1:0]              act_tbuf,
    output logic [NUM_WIN-1:0]              act_burst,
    output logic [NUM_WIN*DSB_FMT_W-1:0]    act_fmt,
    output logic [NUM_WIN*DSB_ADDR_W-1:0]   act_base,
    output logic [NUM_WIN*DSB_POS_W-1:0]    act_tlx,
    output logic [NUM_WIN*DSB_POS_W-1:0]    act_tly,
    output logic [NUM_WIN*DSB_POS_W-1:0]    act_brx,
    output logic [NUM_WIN*DSB_POS_W-1:0]    act_bry,
    output logic [NUM_WIN*DSB_KEY_W-1:0]    act_ckey
);

    win_stage_t [NUM_WIN-1:0] stages;
    win_live_t  [NUM_WIN-1:0] lives;
    logic [NUM_WIN-1:0]       hold;
    logic [NUM_WIN-1:0]       pend;
    logic [NUM_WIN-1:0]       commit;
    logic                     req_set;
    logic                     ctl_sel;

    assign ctl_sel = wr_en & wr_addr[BUS_AW-1];

    dsb_sync_ctrl #(.NUM_WIN(NUM_WIN)) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (ctl_sel),
        .wr_data  (wr_data),
        .vsync    (vsync),
        .hold_o   (hold),
        .pend_o   (pend),
        .commit_o (commit),
        .req_set_o(req_set)
    );

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        logic win_wr;
        assign win_wr = wr_en & ~wr_addr[BUS_AW-1]
                      & (wr_addr[DSB_REG_AW +: WIN_AW] == WIN_AW'(w));

        dsb_window #(.HAS_KEY(w != 0)) win_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (win_wr),
            .wr_off (wr_addr[DSB_REG_AW-1:0]),
            .wr_data(wr_data),
            .commit (commit[w]),
            .stage_o(stages[w]),
            .live_o (lives[w])
        );

        assign act_en[w]                            = lives[w].en;
        assign act_tbuf[w]                          = lives[w].tbuf;
        assign act_burst[w]                         = lives[w].burst;
        assign act_fmt[w*DSB_FMT_W +: DSB_FMT_W]    = lives[w].fmt;
        assign act_base[w*DSB_ADDR_W +: DSB_ADDR_W] = lives[w].base;
        assign act_tlx[w*DSB_POS_W +: DSB_POS_W]    = lives[w].tlx;
        assign act_tly[w*DSB_POS_W +: DSB_POS_W]    = lives[w].tly;
        assign act_brx[w*DSB_POS_W +: DSB_POS_W]    = lives[w].brx;
        assign act_bry[w*DSB_POS_W +: DSB_POS_W]    = lives[w].bry;
        assign act_ckey[w*DSB_KEY_W +: DSB_KEY_W]   = lives[w].ckey;
    end

    dsb_read_mux #(.NUM_WIN(NUM_WIN), .WIN_AW(WIN_AW), .BUS_AW(BUS_AW)) rd_i (
        .stages (stages),
        .hold   (hold),
        .pend   (pend),
        .rd_addr(rd_addr),
        .rd_data(rd_data)
    );

endmodule

// File: rtl/dsb_checker.sv
module dsb_checker
    import dsb_pkg::*;
#(
    parameter int unsigned NUM_WIN = 2
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          vsync,
    input logic [NUM_WIN-1:0]            hold,
    input logic [NUM_WIN-1:0]            pend,
    input logic                          req_set,
    input logic [NUM_WIN-1:0]            act_en,
    input logic [NUM_WIN*DSB_ADDR_W-1:0] act_base,
    input logic [NUM_WIN*DSB_POS_W-1:0]  act_brx
);

    AST_LIVE_ONLY_AT_VSYNC: assert property (@(posedge clk) disable iff (!rst_n)
        !vsync |=> ($stable(act_base) && $stable(act_en) && $stable(act_brx))); // R1

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_chk
        AST_HOLD_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
            hold[w] |=> ($stable(act_base[w*DSB_ADDR_W +: DSB_ADDR_W]) && $stable(act_en[w]))); // R2

        AST_REQ_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
            (vsync && pend[w] && !hold[w] && !req_set) |=> !pend[w]); // R5

        AST_PEND_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pend[w]) |-> $past(req_set)); // R6
    end

endmodule

bind disp_shadow_bank dsb_checker #(.NUM_WIN(NUM_WIN)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .vsync   (vsync),
    .hold    (hold),
    .pend    (pend),
    .req_set (req_set),
    .act_en  (act_en),
    .act_base(act_base),
    .act_brx (act_brx)
);

// File: tb/disp_shadow_bank_tb.sv
`timescale 1ns/1ps
module disp_shadow_bank_tb_top;

    localparam int NW = 2;
    localparam int AW = 5;
    localparam int PW = 12;
    localparam int CTL = 16;
    localparam int NV = 8;
    localparam int V_X [NV] = '{0, 10, 100, 4095, 5, 0, 1, 300};
    localparam int V_Y [NV] = '{0, 20, 50, 4095, 0, 7, 1, 0};
    localparam int V_W [NV] = '{0, 1, 640, 1, 0, 0, 4095, 20};
    localparam int V_H [NV] = '{0, 1, 480, 1, 3, 0, 2, 1};
    localparam int E_X [NV] = '{0, 10, 739, 4095, 4, 0, 4095, 319};
    localparam int E_Y [NV] = '{0, 20, 529, 4095, 2, 6, 2, 0};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [31:0] rd_data;
    logic vsync = 1'b0;
    logic [NW-1:0] act_en, act_tbuf, act_burst;
    logic [NW*4-1:0] act_fmt;
    logic [NW*32-1:0] act_base, act_ckey;
    logic [NW*PW-1:0] act_tlx, act_tly, act_brx, act_bry;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    logic [31:0] rv;

    always #10 clk = ~clk;

    disp_shadow_bank dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .vsync(vsync),
        .act_en(act_en), .act_tbuf(act_tbuf), .act_burst(act_burst), .act_fmt(act_fmt),
        .act_base(act_base), .act_tlx(act_tlx), .act_tly(act_tly),
        .act_brx(act_brx), .act_bry(act_bry), .act_ckey(act_ckey)
    );

    task automatic chk(input string req, input logic [63:0] actual, input logic [63:0] expd);
        checks++;
        if (actual !== expd) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, actual, expd);
        end
    endtask

    task automatic wr(input int addr, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(addr); wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int addr, output logic [31:0] data);
        @(negedge clk);
        rd_addr = AW'(addr);
        #1 data = rd_data;
    endtask

    task automatic pulse_vsync();
        @(negedge clk);
        vsync = 1'b1;
        @(negedge clk);
        vsync = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: everything zero after reset
        chk("R10 live enable", 64'(act_en), 64'h0);
        chk("R10 live base", 64'(act_base), 64'h0);
        rd(CTL, rv); chk("R10 control reg", 64'(rv), 64'h0);
        rd(1, rv);   chk("R10 staged base", 64'(rv), 64'h0);

        // R11: far-corner vectors, alternating windows
        for (int i = 0; i < NV; i++) begin
            int w;
            w = i % 2;
            wr(w*8 + 2, (32'(V_Y[i]) << 16) | 32'(V_X[i]));
            wr(w*8 + 3, (32'(V_H[i]) << 16) | 32'(V_W[i]));
            wr(CTL, 32'h100);
            pulse_vsync();
            chk($sformatf("R11 vec%0d brx", i), 64'(act_brx[w*PW +: PW]), 64'(E_X[i]));
            chk($sformatf("R11 vec%0d bry", i), 64'(act_bry[w*PW +: PW]), 64'(E_Y[i]));
            chk($sformatf("R11 vec%0d tlx", i), 64'(act_tlx[w*PW +: PW]), 64'(V_X[i]));
        end

        // R9 / R1: staged write reads back, live untouched
        wr(1, 32'hA000_1000);
        rd(1, rv); chk("R9 readback", 64'(rv), 64'hA000_1000);
        chk("R1 live before commit", 64'(act_base[31:0]), 64'h0);
        // R6: vsync without request
        pulse_vsync();
        chk("R6 vsync without request", 64'(act_base[31:0]), 64'h0);

        // R5: request, commit, self-clear
        wr(CTL, 32'h100);
        rd(CTL, rv); chk("R5 request visible", 64'(rv[8]), 64'h1);
        pulse_vsync();
        chk("R5 committed base", 64'(act_base[31:0]), 64'hA000_1000);
        rd(CTL, rv); chk("R5 request cleared", 64'(rv[8]), 64'h0);

        // R7: control fields
        wr(0, 32'h0000_00B7);
        wr(8, 32'h0000_0001);
        wr(CTL, 32'h100);
        pulse_vsync();
        chk("R7 enable", 64'(act_en), 64'h3);
        chk("R7 triple buffer", 64'(act_tbuf), 64'h1);
        chk("R7 burst", 64'(act_burst), 64'h1);
        chk("R7 format", 64'(act_fmt[3:0]), 64'hB);

        // R2 / R3: hold window 0 across an update
        wr(CTL, 32'h001);
        wr(1, 32'hB000_0000);
        wr(9, 32'hC000_0000);
        wr(CTL, 32'h101);
        pulse_vsync();
        chk("R2 held window keeps base", 64'(act_base[31:0]), 64'hA000_1000);
        chk("R2 free window commits", 64'(act_base[63:32]), 64'hC000_0000);
        rd(CTL, rv); chk("R5 partial commit keeps request", 64'(rv), 64'h101);
        wr(CTL, 32'h000);
        rd(CTL, rv); chk("R5 writing 0 does not cancel", 64'(rv[8]), 64'h1);
        pulse_vsync();
        chk("R3 released window commits", 64'(act_base[31:0]), 64'hB000_0000);
        rd(CTL, rv); chk("R3 request drained", 64'(rv), 64'h0);

        // R4: disable lands at vsync
        wr(8, 32'h0);
        wr(CTL, 32'h100);
        chk("R4 still enabled before vsync", 64'(act_en[1]), 64'h1);
        pulse_vsync();
        chk("R4 disabled after vsync", 64'(act_en[1]), 64'h0);

        // R8: colour key only on window 1
        wr(4, 32'h1234_5678);
        rd(4, rv); chk("R8 window0 key reads 0", 64'(rv), 64'h0);
        wr(12, 32'h00FF_00FF);
        rd(12, rv); chk("R8 window1 key readback", 64'(rv), 64'h00FF_00FF);
        wr(CTL, 32'h100);
        pulse_vsync();
        chk("R8 window0 live key", 64'(act_ckey[31:0]), 64'h0);
        chk("R8 window1 live key", 64'(act_ckey[63:32]), 64'h00FF_00FF);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule